// File: doc/BRIEF.md
# Priority-Class Interrupt Acceptance Unit

This unit sits on the processor side of an interrupt delivery path and accepts vector messages. Each message carries an 8-bit vector and a 4-bit source tag. The unit records every accepted vector in a 256-bit pending bitmap. It groups the vectors into 16 priority classes, and the class of a vector is its upper nibble. Each class has a two-slot queue that all sixteen of its vectors share. A message that finds its class queue full is turned away in the same cycle, and the sender is expected to try again.

Toward the core, the unit offers one vector at a time. It serves the highest class that has pending work, and within a class it serves the oldest entry first. A vector is offered only when its class is strictly above the class of the vector currently in service, so handlers nest by class. When the core takes the offered vector, the unit moves it from pending to a 256-bit in-service bitmap. An end-of-interrupt strobe carries no vector number. It retires the highest vector in service and, one cycle later, emits a completion notice with that vector and the source tag of the original message, so that the source can release its latch.

Top module: `intc_accept_unit`

## Requirements
- R1: A message that is accepted sets the pending bit of its vector. That vector is later offered on irq_vector exactly once.
- R2: The class of a vector is bits [7:4]. A class holds at most two distinct pending vectors. A message for a third distinct vector of a full class gets msg_reject=1 and msg_accept=0, and is never offered.
- R3: A message whose vector is already pending is accepted and merged. It takes no queue slot and does not cause a second offer.
- R4: Among pending classes, the numerically highest class is offered first.
- R5: Within a class, vectors are offered in arrival order, not in vector-number order.
- R6: irq_valid is 1 only if a class is pending and either nothing is in service or the offered class is strictly greater than the class of the highest in-service vector.
- R7: irq_take while irq_valid=1 removes the vector from pending and puts it in service. A later message with the same vector is then queued as a new entry.
- R8: eoi retires the highest in-service vector. In the following cycle cpl_valid=1 for one cycle, with cpl_vector set to that vector and cpl_source set to the source tag of the message that delivered it.
- R9: eoi with nothing in service has no effect: cpl_valid stays 0 and the offered vector does not change.
- R10: After reset nothing is pending or in service, so irq_valid=0 and cpl_valid=0.
- R11: msg_accept and msg_reject respond combinationally in the cycle msg_valid=1. They are never both 1, and both are 0 when msg_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Incoming vector message present |
| msg_vector | input | 8 | Vector of the incoming message |
| msg_source | input | 4 | Source tag of the incoming message |
| msg_accept | output | 1 | Message accepted this cycle |
| msg_reject | output | 1 | Message refused this cycle (class queue full) |
| irq_valid | output | 1 | A vector is offered to the core |
| irq_vector | output | 8 | Offered vector |
| irq_take | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt for the current in-service vector |
| cpl_valid | output | 1 | Completion notice valid |
| cpl_vector | output | 8 | Retired vector |
| cpl_source | output | 4 | Source tag to release |

## Verification
The hardest state to reach from the ports is a deep nest: several classes in service at once, while lower or equal classes sit pending and must not be offered. The stimulus first fills all sixteen class queues, including merged duplicates and rejected overflow, and drains them one vector at a time. It then builds a three-level sequence by hand: class 3 is in service, a class 2 vector and a second copy of the class 3 vector wait, and a class 5 vector preempts. The bench then checks that each eoi unwinds exactly one level and releases the held vectors in the right order.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int VEC_W  = 8;
    localparam int CLS_W  = 4;
    localparam int IDX_W  = VEC_W - CLS_W;
    localparam int SRC_W  = 4;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int NUM_CLS = 1 << CLS_W;
    localparam int Q_DEPTH = 2;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [SRC_W-1:0] src;
    } q_entry_t;

    function automatic logic [CLS_W-1:0] class_of(input logic [VEC_W-1:0] v);
        return v[VEC_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/intc_prio_find.sv
module intc_prio_find #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] top
);
    always_comb begin
        any = 1'b0;
        top = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                top = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_class_queue.sv
module intc_class_queue #(
    parameter int DEPTH = 2,
    parameter int EW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          full,
    output logic          empty
);
    logic [EW-1:0] slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = slots[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/intc_accept_unit.sv
module intc_accept_unit
    import intc_pkg::*;
#(
    parameter int QDEPTH = Q_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_valid,
    input  logic [VEC_W-1:0] msg_vector,
    input  logic [SRC_W-1:0] msg_source,
    output logic             msg_accept,
    output logic             msg_reject,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector,
    input  logic             irq_take,
    input  logic             eoi,
    output logic             cpl_valid,
    output logic [VEC_W-1:0] cpl_vector,
    output logic [SRC_W-1:0] cpl_source
);
    localparam int EW = $bits(q_entry_t);

    logic [NUM_VEC-1:0] pending, in_service;
    logic [SRC_W-1:0]   svc_src [NUM_CLS];

    logic [NUM_CLS-1:0] q_full, q_empty, q_push, q_pop;
    q_entry_t           q_head [NUM_CLS];

    logic               cls_any, isr_any;
    logic [CLS_W-1:0]   best_cls;
    logic [VEC_W-1:0]   isr_top;

    logic [CLS_W-1:0]   msg_cls;
    logic               take_fire, merge, retire;
    q_entry_t           new_entry;

    // per-class two-slot queues
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        intc_class_queue #(.DEPTH(QDEPTH), .EW(EW)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (q_push[c]),
            .push_data (new_entry),
            .pop       (q_pop[c]),
            .head      (q_head[c]),
            .full      (q_full[c]),
            .empty     (q_empty[c])
        );
        assign q_push[c] = msg_accept && !merge && (msg_cls == CLS_W'(c));
        assign q_pop[c]  = take_fire && (best_cls == CLS_W'(c));
    end

    intc_prio_find #(.N(NUM_CLS)) u_cls_pick (
        .req (~q_empty),
        .any (cls_any),
        .top (best_cls)
    );

    intc_prio_find #(.N(NUM_VEC)) u_isr_pick (
        .req (in_service),
        .any (isr_any),
        .top (isr_top)
    );

    // acceptance
    assign msg_cls       = class_of(msg_vector);
    assign new_entry.idx = msg_vector[IDX_W-1:0];
    assign new_entry.src = msg_source;
    assign merge      = pending[msg_vector] && !(take_fire && irq_vector == msg_vector);
    assign msg_accept = msg_valid && (merge || !q_full[msg_cls]);
    assign msg_reject = msg_valid && !msg_accept;

    // offer to core
    assign irq_vector = {best_cls, q_head[best_cls].idx};
    assign irq_valid  = cls_any && (!isr_any || best_cls > class_of(isr_top));
    assign take_fire  = irq_valid && irq_take;
    assign retire     = eoi && isr_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= '0;
            in_service <= '0;
            cpl_valid  <= 1'b0;
            cpl_vector <= '0;
            cpl_source <= '0;
            for (int c = 0; c < NUM_CLS; c++) svc_src[c] <= '0;
        end else begin
            if (take_fire) pending[irq_vector] <= 1'b0;
            if (msg_accept) pending[msg_vector] <= 1'b1;
            if (retire) in_service[isr_top] <= 1'b0;
            if (take_fire) begin
                in_service[irq_vector] <= 1'b1;
                svc_src[best_cls]      <= q_head[best_cls].src;
            end
            cpl_valid <= retire;
            if (retire) begin
                cpl_vector <= isr_top;
                cpl_source <= svc_src[class_of(isr_top)];
            end
        end
    end

    p_resp_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(msg_accept && msg_reject));
    p_resp_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |-> !(msg_accept || msg_reject));
    p_pending_set_r1: assert property (@(posedge clk) disable iff (rst)
        msg_accept |=> pending[$past(msg_vector)]);
    p_take_moves_r7: assert property (@(posedge clk) disable iff (rst)
        take_fire && !(msg_accept && msg_vector == irq_vector)
        |=> in_service[$past(irq_vector)] && !pending[$past(irq_vector)]);
    p_nest_rank_r6: assert property (@(posedge clk) disable iff (rst)
        irq_valid && isr_any |-> class_of(irq_vector) > class_of(isr_top));
    p_retire_cpl_r8: assert property (@(posedge clk) disable iff (rst)
        retire |=> cpl_valid && cpl_vector == $past(isr_top));
    p_idle_eoi_r9: assert property (@(posedge clk) disable iff (rst)
        (eoi && !isr_any) |=> !cpl_valid);
endmodule

// File: tb/intc_accept_unit_test.sv
module intc_accept_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_vector = '0;
    logic [3:0] msg_source = '0;
    logic       msg_accept, msg_reject, irq_valid, irq_take = 1'b0, eoi = 1'b0;
    logic [7:0] irq_vector, cpl_vector;
    logic [3:0] cpl_source;
    logic       cpl_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    intc_accept_unit uut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_vector(msg_vector),
        .msg_source(msg_source), .msg_accept(msg_accept), .msg_reject(msg_reject),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_take(irq_take),
        .eoi(eoi), .cpl_valid(cpl_valid), .cpl_vector(cpl_vector), .cpl_source(cpl_source)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] v, input logic [3:0] s, input bit exp_acc,
                        input string req);
        @(negedge clk);
        msg_valid = 1'b1; msg_vector = v; msg_source = s;
        #1;
        chk(msg_accept == exp_acc && msg_reject == !exp_acc, req, "accept", msg_accept, exp_acc);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic take(input logic [7:0] v, input string req);
        @(negedge clk);
        chk(irq_valid == 1'b1 && irq_vector == v, req, "offered vector",
            irq_valid ? irq_vector : 'h1ff, v);
        irq_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0;
    endtask

    task automatic retire(input bit exp_cpl, input logic [7:0] v, input logic [3:0] s,
                          input string req);
        @(negedge clk);
        eoi = 1'b1;
        @(posedge clk); #1;
        chk(cpl_valid == exp_cpl, req, "cpl_valid", cpl_valid, exp_cpl);
        if (exp_cpl) begin
            chk(cpl_vector == v, req, "cpl_vector", cpl_vector, v);
            chk(cpl_source == s, req, "cpl_source", cpl_source, s);
        end
        @(negedge clk);
        eoi = 1'b0;
        @(posedge clk); #1;
        chk(cpl_valid == 1'b0, req, "cpl pulse width", cpl_valid, 0);
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk); #1;
        chk(irq_valid == 1'b0, req, "irq_valid", irq_valid, 0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(irq_valid == 0, "R10", "irq_valid", irq_valid, 0);
        chk(cpl_valid == 0, "R10", "cpl_valid", cpl_valid, 0);
        chk(!msg_accept && !msg_reject, "R11", "idle response", msg_accept, 0);

        retire(1'b0, 8'h00, 4'h0, "R9");
        idle_chk("R9");

        // fill every class: two distinct, one merged duplicate, one overflow
        for (int c = 0; c < 16; c++) begin
            send(8'(c * 16 + 9), 4'(c), 1'b1, "R1");
            send(8'(c * 16 + 2), 4'(c + 5), 1'b1, "R1");
            send(8'(c * 16 + 9), 4'(c + 9), 1'b1, "R3");
            send(8'(c * 16 + 5), 4'(c + 1), 1'b0, "R2");
        end

        // drain: highest class first, arrival order within class
        for (int c = 15; c >= 0; c--) begin
            take(8'(c * 16 + 9), "R4");
            idle_chk("R6");
            retire(1'b1, 8'(c * 16 + 9), 4'(c), "R8");
            take(8'(c * 16 + 2), "R5");
            idle_chk("R6");
            retire(1'b1, 8'(c * 16 + 2), 4'(c + 5), "R8");
        end
        idle_chk("R3");

        // nesting
        send(8'h35, 4'h1, 1'b1, "R1");
        take(8'h35, "R7");
        send(8'h22, 4'h2, 1'b1, "R1");
        idle_chk("R6");
        send(8'h35, 4'h4, 1'b1, "R7");
        idle_chk("R6");
        send(8'h5A, 4'h3, 1'b1, "R1");
        take(8'h5A, "R6");
        retire(1'b1, 8'h5A, 4'h3, "R8");
        idle_chk("R6");
        retire(1'b1, 8'h35, 4'h1, "R8");
        take(8'h35, "R7");
        retire(1'b1, 8'h35, 4'h4, "R8");
        take(8'h22, "R4");
        retire(1'b1, 8'h22, 4'h2, "R8");
        idle_chk("R1");
        retire(1'b0, 8'h00, 4'h0, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule